// File: doc/BRIEF.md
# Boot Mode Reset Controller

This block produces a long, stretchable reset for an attached microcontroller and decides whether the device comes out of that reset in its normal user mode or in its boot (reprogramming) mode. Three active-low inputs control it: a reset push-button, a boot push-button and a serial CTS line that a host can pull low to ask for a mode change remotely. Every input is brought into the clock domain through a synchronizer. A falling-edge detector then turns each activation into a single request.

The controller is a four-state machine built from two pairs. The user pair is user-reset followed by user-running. The boot pair is boot-reset followed by boot-waiting. The first state of each pair holds the device in reset until a reload-able timer reaches its terminal count. Holding or pressing any control again reloads the timer. While the machine is in a boot state, the mode pins are driven to a fixed boot encoding through output enables. While it is in a user state, the pins are released so that board pulls set the user mode. A status line and an LED report which mode is active.

Top module: `boot_reset_ctrl`

## Requirements
- R1: Before the first clock edge and while `rst` is high, `dev_rst_n` is 0, `mode_oe` is all zeros, and `boot_led` and `rts` are 0. After `rst` falls, the device is released in user mode with `boot_led` = 0.
- R2: `dev_rst_n` goes high only after the reset timer has reached its terminal count. It is low exactly in the user-reset and boot-reset states.
- R3: While any of the three control inputs is held low, the timer is reloaded. The reset period ends TERM+1 cycles after the last control input returns high, where TERM is defined in R11.
- R4: In user-running, a boot-button press or a CTS falling edge moves the machine to boot-reset. When the timer expires, the machine moves to boot-waiting.
- R5: In boot-waiting, a boot-button press or a CTS falling edge moves the machine to user-reset, which ends in user-running.
- R6: A boot-button press or CTS falling edge that arrives during user-reset or boot-reset does not change the mode. It only extends the reset.
- R7: A reset-button press in any state moves the machine to user-reset. A reset press takes priority over a simultaneous boot request.
- R8: In both boot states, `mode_oe` is all ones and `mode_out` equals BOOT_CODE. With the defaults this is 3'b010, i.e. mode 2, with bit 1 set. In both user states, `mode_oe` is all zeros and `mode_out` is 0.
- R9: `rts` and `boot_led` are 1 in both boot states and 0 in both user states.
- R10: A single low period on an input produces exactly one toggle, however long it lasts. The first output effect is visible after the third rising clock edge that follows the input change.
- R11: TERM = (CLK_HZ/1000)*RESET_MS cycles. After `rst` is released, `dev_rst_n` stays low for TERM-1 further cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_btn_n | input | 1 | Reset push-button, active low, asynchronous |
| boot_btn_n | input | 1 | Boot push-button, active low, asynchronous |
| cts_n | input | 1 | Remote boot request line, active low, asynchronous |
| dev_rst_n | output | 1 | Active-low reset to the microcontroller |
| mode_out | output | MODE_W | Value for the mode-pin tri-state buffers |
| mode_oe | output | MODE_W | Output enables for the mode-pin tri-state buffers |
| boot_led | output | 1 | Boot-mode indicator |
| rts | output | 1 | Mode status to the host: 1 = boot, 0 = user |

## Verification
An input change passes through two synchronizer flops and then reaches the state register. Every state-derived output therefore moves after the third rising edge that follows the input change. The bench drives inputs on falling edges and samples outputs on later falling edges, so it reads each output one clock after the value settles, with no race.

Reset length is measured the same way. The bench counts low samples of `dev_rst_n` starting at the first falling edge after the last control input is released, and expects TERM+1 of them. After `rst` falls it expects TERM-1.

// File: rtl/brc_pkg.sv
package brc_pkg;

    // State code: bit 1 = boot pair, bit 0 = second (non-reset) state of the pair
    typedef enum logic [1:0] {
        ST_USR_RST   = 2'b00,
        ST_USR_RUN   = 2'b01,
        ST_BOOT_RST  = 2'b10,
        ST_BOOT_WAIT = 2'b11
    } brc_state_e;

    // Requests presented to the state machine, already synchronized
    typedef struct packed {
        logic rst_fall;   // new reset-button activation
        logic boot_req;   // new boot-button or CTS activation
        logic any_held;   // any control currently active
    } brc_evt_t;

    // Channel indices of the synchronizer bank
    localparam int CH_RST  = 0;
    localparam int CH_BOOT = 1;
    localparam int CH_CTS  = 2;
    localparam int N_CH    = 3;

    function automatic logic st_is_boot(brc_state_e s);
        return s[1];
    endfunction

    function automatic logic st_in_reset(brc_state_e s);
        return ~s[0];
    endfunction

    function automatic int unsigned term_count(int unsigned hz, int unsigned ms);
        return (hz / 1000) * ms;
    endfunction

endpackage

// File: rtl/brc_sync_edge.sv
module brc_sync_edge #(
    parameter int STAGES = 2,
    parameter int N      = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] in_n,
    output logic [N-1:0] act,
    output logic [N-1:0] fall
);

    for (genvar c = 0; c < N; c++) begin : g_ch
        logic [STAGES-1:0] sh_q   = '1;
        logic              last_q = 1'b1;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q   <= '1;
                last_q <= 1'b1;
            end else begin
                sh_q   <= {sh_q[STAGES-2:0], in_n[c]};
                last_q <= sh_q[STAGES-1];
            end
        end

        assign act[c]  = ~sh_q[STAGES-1];
        assign fall[c] = last_q & ~sh_q[STAGES-1];

        // R10
        one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
            fall[c] |=> !fall[c]);
    end

endmodule

// File: rtl/brc_reset_timer.sv
module brc_reset_timer #(
    parameter int unsigned TERM  = 20,
    parameter int          CNT_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TERM - 1);

    logic [CNT_W-1:0] cnt_q = LOAD;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !expired);

endmodule

// File: rtl/brc_mode_fsm.sv
module brc_mode_fsm
    import brc_pkg::*;
#(
    parameter int MODE_W    = 3,
    parameter int BOOT_CODE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  brc_evt_t          evt_i,
    input  logic              expired_i,
    output logic              dev_rst_n_o,
    output logic [MODE_W-1:0] mode_out_o,
    output logic [MODE_W-1:0] mode_oe_o,
    output logic              boot_led_o,
    output logic              rts_o
);

    brc_state_e state_q = ST_USR_RST;
    brc_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (evt_i.rst_fall) begin
            state_d = ST_USR_RST;
        end else begin
            unique case (state_q)
                ST_USR_RST:   if (expired_i)      state_d = ST_USR_RUN;
                ST_USR_RUN:   if (evt_i.boot_req) state_d = ST_BOOT_RST;
                ST_BOOT_RST:  if (expired_i)      state_d = ST_BOOT_WAIT;
                ST_BOOT_WAIT: if (evt_i.boot_req) state_d = ST_USR_RST;
                default:                          state_d = ST_USR_RST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_USR_RST;
        else     state_q <= state_d;
    end

    always_comb begin
        dev_rst_n_o = ~st_in_reset(state_q);
        boot_led_o  = st_is_boot(state_q);
        rts_o       = st_is_boot(state_q);
        mode_oe_o   = {MODE_W{st_is_boot(state_q)}};
        mode_out_o  = st_is_boot(state_q) ? MODE_W'(BOOT_CODE) : '0;
    end

    // R2
    release_after_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_rst_n_o) |-> $past(expired_i));

    // R6
    user_rst_no_boot_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_USR_RST) |=> !st_is_boot(state_q));

    // R6
    boot_rst_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT_RST && !evt_i.rst_fall) |=> st_is_boot(state_q));

    // R4
    boot_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_USR_RUN && evt_i.boot_req && !evt_i.rst_fall)
        |=> state_q == ST_BOOT_RST);

    // R5
    user_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT_WAIT && evt_i.boot_req && !evt_i.rst_fall)
        |=> state_q == ST_USR_RST);

    // R7
    rst_press_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i.rst_fall |=> (state_q == ST_USR_RST && !dev_rst_n_o));

endmodule

// File: rtl/boot_reset_ctrl.sv
module boot_reset_ctrl
    import brc_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned RESET_MS    = 500,
    parameter int          SYNC_STAGES = 2,
    parameter int          MODE_W      = 3,
    parameter int          BOOT_CODE   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_btn_n,
    input  logic              boot_btn_n,
    input  logic              cts_n,
    output logic              dev_rst_n,
    output logic [MODE_W-1:0] mode_out,
    output logic [MODE_W-1:0] mode_oe,
    output logic              boot_led,
    output logic              rts
);

    localparam int unsigned TERM  = term_count(CLK_HZ, RESET_MS);
    localparam int          CNT_W = $clog2(TERM + 1);

    logic [N_CH-1:0] raw_n;
    logic [N_CH-1:0] act;
    logic [N_CH-1:0] fall;
    brc_evt_t        evt;
    logic            expired;

    always_comb begin
        raw_n          = '1;
        raw_n[CH_RST]  = rst_btn_n;
        raw_n[CH_BOOT] = boot_btn_n;
        raw_n[CH_CTS]  = cts_n;
    end

    brc_sync_edge #(
        .STAGES (SYNC_STAGES),
        .N      (N_CH)
    ) i_sync (
        .clk  (clk),
        .rst  (rst),
        .in_n (raw_n),
        .act  (act),
        .fall (fall)
    );

    always_comb begin
        evt.rst_fall = fall[CH_RST];
        evt.boot_req = fall[CH_BOOT] | fall[CH_CTS];
        evt.any_held = |act;
    end

    brc_reset_timer #(
        .TERM  (TERM),
        .CNT_W (CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (evt.any_held),
        .expired (expired)
    );

    brc_mode_fsm #(
        .MODE_W    (MODE_W),
        .BOOT_CODE (BOOT_CODE)
    ) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .expired_i   (expired),
        .dev_rst_n_o (dev_rst_n),
        .mode_out_o  (mode_out),
        .mode_oe_o   (mode_oe),
        .boot_led_o  (boot_led),
        .rts_o       (rts)
    );

    // R1
    safe_in_rst_chk: assert property (@(posedge clk)
        rst |=> (!dev_rst_n && mode_oe == '0 && !boot_led));

endmodule

// File: tb/test_boot_reset_ctrl.sv
module test_boot_reset_ctrl;

    localparam int unsigned CLK_HZ   = 1000;
    localparam int unsigned RESET_MS = 20;
    localparam int          TERM     = 20;
    localparam int          MODE_W   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rst_btn_n = 1'b1;
    logic              boot_btn_n = 1'b1;
    logic              cts_n = 1'b1;
    logic              dev_rst_n;
    logic [MODE_W-1:0] mode_out;
    logic [MODE_W-1:0] mode_oe;
    logic              boot_led;
    logic              rts;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    boot_reset_ctrl #(
        .CLK_HZ   (CLK_HZ),
        .RESET_MS (RESET_MS),
        .MODE_W   (MODE_W)
    ) i_boot_reset_ctrl (
        .clk        (clk),
        .rst        (rst),
        .rst_btn_n  (rst_btn_n),
        .boot_btn_n (boot_btn_n),
        .cts_n      (cts_n),
        .dev_rst_n  (dev_rst_n),
        .mode_out   (mode_out),
        .mode_oe    (mode_oe),
        .boot_led   (boot_led),
        .rts        (rts)
    );

    // src: 0 = reset button, 1 = boot button, 2 = CTS
    typedef struct packed {
        logic [1:0] src;
        logic       exp_boot;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b1},
        '{2'd2, 1'b0},
        '{2'd2, 1'b1},
        '{2'd0, 1'b0},
        '{2'd1, 1'b1},
        '{2'd1, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_src(input int src, input logic v);
        case (src)
            0:       rst_btn_n  = v;
            1:       boot_btn_n = v;
            default: cts_n      = v;
        endcase
    endtask

    task automatic press(input int src, input int hold);
        set_src(src, 1'b0);
        repeat (hold) @(negedge clk);
        set_src(src, 1'b1);
    endtask

    task automatic wait_release(output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!dev_rst_n) n++;
            else break;
        end
    endtask

    task automatic chk_mode(input logic b, input string tag);
        chk(boot_led == b, {tag, " R9 boot_led"}, int'(boot_led), int'(b));
        chk(rts == b, {tag, " R9 rts"}, int'(rts), int'(b));
        chk(mode_oe == {MODE_W{b}}, {tag, " R8 mode_oe"}, int'(mode_oe), b ? 7 : 0);
        chk(mode_out == (b ? 3'b010 : 3'b000), {tag, " R8 mode_out"},
            int'(mode_out), b ? 2 : 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        #1;
        // R1: safe values before the first clock edge
        chk(dev_rst_n == 1'b0, "R1 pre-clock dev_rst_n", int'(dev_rst_n), 0);
        chk(mode_oe == '0, "R1 pre-clock mode_oe", int'(mode_oe), 0);
        chk(boot_led == 1'b0, "R1 pre-clock boot_led", int'(boot_led), 0);
        chk(rts == 1'b0, "R1 pre-clock rts", int'(rts), 0);

        repeat (4) @(negedge clk);
        chk(dev_rst_n == 1'b0, "R1 in rst dev_rst_n", int'(dev_rst_n), 0);
        rst = 1'b0;
        wait_release(n);
        // R11: TERM-1 low samples after rst release
        chk(n == TERM - 1, "R11 power-up reset length", n, TERM - 1);
        chk_mode(1'b0, "R1 after power-up");

        // Vector table: each press ends in the expected mode
        for (int v = 0; v < NV; v++) begin
            press(int'(VECS[v].src), 3);
            wait_release(n);
            chk(n == TERM + 1, "R3 reset length after press", n, TERM + 1);
            // R4 (boot/CTS into boot), R5 (back to user), R7 (reset button)
            chk_mode(VECS[v].exp_boot,
                     VECS[v].src == 2'd0 ? "R7 vec" : (VECS[v].exp_boot ? "R4 vec" : "R5 vec"));
        end

        // R10: latency and single toggle on a long hold
        boot_btn_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(boot_led == 1'b0, "R10 no effect after two edges", int'(boot_led), 0);
        @(negedge clk);
        chk(boot_led == 1'b1, "R10 effect after third edge", int'(boot_led), 1);
        chk(dev_rst_n == 1'b0, "R4 boot-reset asserted", int'(dev_rst_n), 0);
        chk_mode(1'b1, "R8 during boot-reset");
        repeat (30) @(negedge clk);
        chk(dev_rst_n == 1'b0, "R3 held button extends reset", int'(dev_rst_n), 0);
        chk(boot_led == 1'b1, "R10 long hold one toggle", int'(boot_led), 1);
        boot_btn_n = 1'b1;
        wait_release(n);
        chk(n == TERM + 1, "R3 reset length after hold", n, TERM + 1);
        chk_mode(1'b1, "R10 boot-waiting after hold");

        // R5 then R6: CTS during user-reset is ignored
        press(1, 3);
        repeat (5) @(negedge clk);
        chk(boot_led == 1'b0, "R5 boot-wait to user-reset", int'(boot_led), 0);
        press(2, 3);
        wait_release(n);
        chk(n == TERM + 1, "R6 request extends user-reset", n, TERM + 1);
        chk_mode(1'b0, "R6 user-reset ignores CTS");

        // R6: boot press during boot-reset is ignored
        press(1, 3);
        repeat (5) @(negedge clk);
        press(1, 3);
        wait_release(n);
        chk_mode(1'b1, "R6 boot-reset ignores boot press");

        // R7: reset button during boot-reset returns to user
        press(1, 3);
        wait_release(n);
        chk_mode(1'b0, "R5 toggle back to user");
        press(1, 3);
        repeat (5) @(negedge clk);
        press(0, 3);
        chk(boot_led == 1'b0, "R7 reset press leaves boot", int'(boot_led), 0);
        chk(dev_rst_n == 1'b0, "R7 reset held", int'(dev_rst_n), 0);
        wait_release(n);
        chk(n == TERM + 1, "R7 reset length", n, TERM + 1);
        chk_mode(1'b0, "R7 ends in user mode");

        finish_run();
    end

endmodule